// File: doc/BRIEF.md
# SPI Nonvolatile Memory Command Controller

This block is the serial front end of a small nonvolatile byte memory. It acts as an SPI slave in mode 0. A bus master drives the serial clock, an active-low select and the serial data in, and reads the serial data out. The block samples all bus inputs into its own clock domain and assembles bytes, most significant bit first. It decodes the first byte of each selected transfer as an op-code and runs the command against a 2 KB internal byte array and a one-byte status register.

Every change to the status register or the array is gated by a write enable latch. After reset the latch is clear. A dedicated op-code sets it, and another clears it. The latch clears itself when the master deselects after a write that carried at least one full data byte. A status register write cannot change the latch. Commands fall into three groups. Some take no operand. Some move one status byte. The rest take a two-byte address followed by a data stream that advances through the array and wraps at its end.

Top module: `spi_fram_ctrl`

## Requirements
- R1: Bytes move most significant bit first. MOSI is taken on a rising SCK edge and MISO changes only after a falling SCK edge. MISO is 0 while the chip is deselected.
- R2: The op-codes are: 0x06 set latch, 0x04 clear latch, 0x05 status read, 0x01 status write, 0x03 array read, 0x02 array write, 0x9F identity read.
- R3: After reset the write enable latch is clear and a status read returns 0x00.
- R4: 0x06 sets the latch, shown as status bit 1. 0x04 clears it. Neither op-code takes an operand.
- R5: A status read returns the status byte in every byte slot after the op-code. Bit 1 is the latch. Bits 7, 3 and 2 are plain storage. All other bits read 0.
- R6: A status write (0x01 plus one byte) stores bits 7, 3 and 2 only when the latch is set. The value written to bit 1 has no effect on the latch.
- R7: An array write (0x02, address high byte, address low byte, data) stores each full data byte only when the latch was set at the op-code. Only the low 11 address bits are used.
- R8: An array read (0x03, two address bytes) streams bytes starting at the address. The address advances after each byte and wraps from 0x7FF to 0x000. Array writes advance and wrap the same way.
- R9: When the chip is deselected after a status write or an array write that received at least one full data byte, the latch clears.
- R10: Deselecting in the middle of a byte discards that byte with no state change. An array write deselected before any full data byte leaves the latch set.
- R11: An unknown op-code is ignored until deselect. Later bytes in the same transfer change no state, and MISO stays 0.
- R12: The identity read (0x9F) returns the bytes 0x5A, 0xA5, 0x3C in that order and then repeats them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock; bus inputs are oversampled on it |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from the master (idle low) |
| cs_ni | input | 1 | Active-low chip select |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |

## Verification
A wrong latch value shows up at bit 1 of the next status read. It also shows up as array bytes that do or do not change on the next array read, a single transfer after the fault. A wrong bit count or a wrong address counter corrupts the very next byte shifted out, so the streaming read and wrap checks expose it within one byte. A state machine stuck after an unknown or aborted command shows up as non-zero MISO, or as a status change, in the same or the following transfer.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_RDID  = 8'h9F;

  typedef enum logic [3:0] {
    ST_OP, ST_AHI, ST_ALO, ST_RD, ST_WR, ST_SRRD, ST_SRWR, ST_ID, ST_DONE, ST_IGN
  } state_e;
endpackage

// File: rtl/sfc_sync.sv
module sfc_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[g] <= RST_VAL;
        else         stage_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[g] <= RST_VAL;
        else         stage_q[g] <= stage_q[g-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sfc_shifter.sv
module sfc_shifter (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_i,
  input  logic       csn_i,
  input  logic       mosi_i,
  input  logic [7:0] tx_byte_i,
  output logic       rx_vld_o,
  output logic [7:0] rx_byte_o,
  output logic       cs_rise_o,
  output logic       miso_o
);
  logic       sck_q, csn_q;
  logic [2:0] bit_cnt_q;
  logic [6:0] rx_sr_q;
  logic [7:0] tx_sr_q;
  logic       rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sck_q <= 1'b0;
      csn_q <= 1'b1;
    end else begin
      sck_q <= sck_i;
      csn_q <= csn_i;
    end

  assign rise      = sck_i & ~sck_q & ~csn_i;
  assign fall      = ~sck_i & sck_q & ~csn_i;
  assign cs_rise_o = csn_i & ~csn_q;
  assign rx_vld_o  = rise && (bit_cnt_q == 3'd7);
  assign rx_byte_o = {rx_sr_q, mosi_i};

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      rx_sr_q   <= '0;
    end else if (csn_i) begin
      bit_cnt_q <= '0;
    end else if (rise) begin
      bit_cnt_q <= bit_cnt_q + 3'd1;
      rx_sr_q   <= {rx_sr_q[5:0], mosi_i};
    end

  // next response byte is loaded on byte completion, shifted out on falls
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      tx_sr_q <= '0;
      miso_o  <= 1'b0;
    end else if (csn_i) begin
      tx_sr_q <= '0;
      miso_o  <= 1'b0;
    end else if (rx_vld_o) begin
      tx_sr_q <= tx_byte_i;
    end else if (fall) begin
      miso_o  <= tx_sr_q[7];
      tx_sr_q <= {tx_sr_q[6:0], 1'b0};
    end

  p_miso_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_i |=> !miso_o);
endmodule

// File: rtl/sfc_mem.sv
module sfc_mem #(
  parameter int DEPTH = 2048,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i)
    if (we_i) mem_q[addr_i] <= wdata_i;

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/sfc_cmd.sv
module sfc_cmd
  import sfc_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter logic [7:0] SR_WMASK = 8'h8C,
  parameter int ID_BYTES = 3,
  parameter logic [ID_BYTES*8-1:0] ID_WORD = 24'h5AA53C,
  localparam int HI_W = ADDR_W - 8,
  localparam int IDX_W = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csn_i,
  input  logic              cs_rise_i,
  input  logic              rx_vld_i,
  input  logic [7:0]        rx_byte_i,
  output logic [7:0]        tx_byte_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_rdata_i
);
  localparam logic [7:0] SR_MASK = SR_WMASK & 8'hFC;

  state_e            st_q;
  logic              wel_q, wr_ok_q, wr_done_q, is_wr_q;
  logic [7:0]        sr_q, sr_rd;
  logic [HI_W-1:0]   ahi_q;
  logic [ADDR_W-1:0] addr_q, full_addr;
  logic [IDX_W-1:0]  id_idx_q;

  function automatic logic [7:0] id_byte(input logic [IDX_W-1:0] i);
    return ID_WORD[(ID_BYTES-1-int'(i))*8 +: 8];
  endfunction

  assign sr_rd      = sr_q | {6'b0, wel_q, 1'b0};
  assign full_addr  = {ahi_q, rx_byte_i};
  assign mem_addr_o = (st_q == ST_ALO) ? full_addr : addr_q;
  assign mem_we_o   = rx_vld_i && (st_q == ST_WR) && wr_ok_q;

  always_comb begin
    tx_byte_o = '0;
    case (st_q)
      ST_OP: begin
        if (rx_byte_i == OP_RDSR)      tx_byte_o = sr_rd;
        else if (rx_byte_i == OP_RDID) tx_byte_o = id_byte('0);
      end
      ST_ALO:  if (!is_wr_q) tx_byte_o = mem_rdata_i;
      ST_RD:   tx_byte_o = mem_rdata_i;
      ST_SRRD: tx_byte_o = sr_rd;
      ST_ID:   tx_byte_o = id_byte(id_idx_q);
      default: tx_byte_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q      <= ST_OP;
      wel_q     <= 1'b0;
      wr_ok_q   <= 1'b0;
      wr_done_q <= 1'b0;
      is_wr_q   <= 1'b0;
      sr_q      <= '0;
      ahi_q     <= '0;
      addr_q    <= '0;
      id_idx_q  <= '0;
    end else if (csn_i) begin
      st_q      <= ST_OP;
      wr_done_q <= 1'b0;
      if (cs_rise_i && wr_done_q) wel_q <= 1'b0;
    end else if (rx_vld_i) begin
      case (st_q)
        ST_OP: begin
          case (rx_byte_i)
            OP_WREN:  begin wel_q <= 1'b1; st_q <= ST_DONE; end
            OP_WRDI:  begin wel_q <= 1'b0; st_q <= ST_DONE; end
            OP_RDSR:  st_q <= ST_SRRD;
            OP_WRSR:  begin wr_ok_q <= wel_q; st_q <= ST_SRWR; end
            OP_READ:  begin is_wr_q <= 1'b0; st_q <= ST_AHI; end
            OP_WRITE: begin is_wr_q <= 1'b1; wr_ok_q <= wel_q; st_q <= ST_AHI; end
            OP_RDID:  begin id_idx_q <= IDX_W'(1 % ID_BYTES); st_q <= ST_ID; end
            default:  st_q <= ST_IGN;
          endcase
        end
        ST_AHI: begin
          ahi_q <= rx_byte_i[HI_W-1:0];
          st_q  <= ST_ALO;
        end
        ST_ALO: begin
          addr_q <= is_wr_q ? full_addr : full_addr + ADDR_W'(1);
          st_q   <= is_wr_q ? ST_WR : ST_RD;
        end
        ST_RD: addr_q <= addr_q + ADDR_W'(1);
        ST_WR: begin
          addr_q <= addr_q + ADDR_W'(1);
          if (wr_ok_q) wr_done_q <= 1'b1;
        end
        ST_SRWR: begin
          if (wr_ok_q) begin
            sr_q      <= rx_byte_i & SR_MASK;
            wr_done_q <= 1'b1;
          end
          st_q <= ST_DONE;
        end
        ST_ID: id_idx_q <= (id_idx_q == IDX_W'(ID_BYTES-1)) ? '0 : id_idx_q + IDX_W'(1);
        default: ;
      endcase
    end

  p_wr_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> wel_q);
  p_wel_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise_i && wr_done_q) |=> !wel_q);
  p_wel_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_vld_i && st_q == ST_SRWR) |=> (wel_q == $past(wel_q)) || csn_i);
  p_ign_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IGN) |=> $stable(wel_q) && $stable(sr_q));
  p_rd_inc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_vld_i && st_q == ST_RD) |=> addr_q == $past(addr_q) + ADDR_W'(1));
endmodule

// File: rtl/spi_fram_ctrl.sv
module spi_fram_ctrl #(
  parameter int MEM_BYTES = 2048,
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] SR_WMASK = 8'h8C,
  parameter int ID_BYTES = 3,
  parameter logic [ID_BYTES*8-1:0] ID_WORD = 24'h5AA53C,
  localparam int ADDR_W = $clog2(MEM_BYTES)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic miso_o
);
  logic              sck_s, csn_s, mosi_s;
  logic              rx_vld, cs_rise, mem_we;
  logic [7:0]        rx_byte, tx_byte, mem_rdata;
  logic [ADDR_W-1:0] mem_addr;

  sfc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, cs_ni, mosi_i}),
    .q_o   ({sck_s, csn_s, mosi_s})
  );

  sfc_shifter u_shifter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sck_i    (sck_s),
    .csn_i    (csn_s),
    .mosi_i   (mosi_s),
    .tx_byte_i(tx_byte),
    .rx_vld_o (rx_vld),
    .rx_byte_o(rx_byte),
    .cs_rise_o(cs_rise),
    .miso_o   (miso_o)
  );

  sfc_cmd #(
    .ADDR_W(ADDR_W), .SR_WMASK(SR_WMASK), .ID_BYTES(ID_BYTES), .ID_WORD(ID_WORD)
  ) u_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .csn_i      (csn_s),
    .cs_rise_i  (cs_rise),
    .rx_vld_i   (rx_vld),
    .rx_byte_i  (rx_byte),
    .tx_byte_o  (tx_byte),
    .mem_we_o   (mem_we),
    .mem_addr_o (mem_addr),
    .mem_rdata_i(mem_rdata)
  );

  sfc_mem #(.DEPTH(MEM_BYTES)) u_mem (
    .clk_i  (clk_i),
    .we_i   (mem_we),
    .addr_i (mem_addr),
    .wdata_i(rx_byte),
    .rdata_o(mem_rdata)
  );
endmodule

// File: tb/spi_fram_ctrl_bench.sv
module spi_fram_ctrl_bench;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  spi_fram_ctrl u_spi_fram_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .mosi_i(mosi), .miso_o(miso)
  );

  task automatic check(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %02h exp %02h", req, what, got, exp);
    end
  endtask

  task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    bits(tx, 8, rx);
  endtask

  task automatic sel();
    @(negedge clk); cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic desel();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1; mosi = 1'b0;
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic op1(input logic [7:0] op);
    logic [7:0] d;
    sel(); xfer(op, d); desel();
  endtask

  task automatic rd_sr(output logic [7:0] s);
    logic [7:0] d;
    sel(); xfer(8'h05, d); xfer(8'h00, s); desel();
  endtask

  task automatic wr_sr(input logic [7:0] v);
    logic [7:0] d;
    sel(); xfer(8'h01, d); xfer(v, d); desel();
  endtask

  task automatic mem_wr(input logic [15:0] a, input logic [31:0] data, input int n);
    logic [7:0] d;
    sel(); xfer(8'h02, d); xfer(a[15:8], d); xfer(a[7:0], d);
    for (int k = 0; k < n; k++) xfer(data[8*k +: 8], d);
    desel();
  endtask

  task automatic mem_rd(input logic [15:0] a, input int n, output logic [31:0] data);
    logic [7:0] d;
    data = '0;
    sel(); xfer(8'h03, d); xfer(a[15:8], d); xfer(a[7:0], d);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, d);
      data[8*k +: 8] = d;
    end
    desel();
  endtask

  task automatic t_reset();
    logic [7:0] s;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1", "miso idle while deselected", {7'b0, miso}, 8'h00);
    rd_sr(s);
    check("R3", "status after reset", s, 8'h00);
  endtask

  task automatic t_latch();
    logic [7:0] s;
    op1(8'h06); rd_sr(s);
    check("R4", "status after set-latch op", s, 8'h02);
    op1(8'h04); rd_sr(s);
    check("R2", "status after clear-latch op", s, 8'h00);
  endtask

  task automatic t_sr_repeat();
    logic [7:0] d, s0, s1;
    op1(8'h06);
    sel(); xfer(8'h05, d); xfer(8'h00, s0); xfer(8'h00, s1); desel();
    check("R5", "status slot 1", s0, 8'h02);
    check("R5", "status slot 2", s1, 8'h02);
    op1(8'h04);
  endtask

  task automatic t_wrsr();
    logic [7:0] s;
    wr_sr(8'hFF); rd_sr(s);
    check("R6", "status write without latch", s, 8'h00);
    op1(8'h06); wr_sr(8'hFF); rd_sr(s);
    check("R6", "status write masks bits, latch cleared", s, 8'h8C);
    op1(8'h06); wr_sr(8'h00); rd_sr(s);
    check("R9", "status write clears bits and latch", s, 8'h00);
  endtask

  task automatic t_mem();
    logic [7:0]  s;
    logic [31:0] d;
    op1(8'h06); mem_wr(16'h0123, 32'h00C3B2A1, 3);
    rd_sr(s);
    check("R9", "latch cleared after array write", s, 8'h00);
    mem_rd(16'h0123, 3, d);
    check("R1", "read byte 0 msb first", d[7:0], 8'hA1);
    check("R8", "read byte 1 incremented", d[15:8], 8'hB2);
    check("R8", "read byte 2 incremented", d[23:16], 8'hC3);
    mem_wr(16'h0123, 32'h55, 1);
    mem_rd(16'h0123, 1, d);
    check("R7", "array write without latch", d[7:0], 8'hA1);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    op1(8'h06); mem_wr(16'hFFFF, 32'h2211, 2);
    mem_rd(16'h07FF, 2, d);
    check("R7", "upper address bits ignored on write", d[7:0], 8'h11);
    check("R8", "read wraps to 0x000", d[15:8], 8'h22);
    mem_rd(16'hF800, 1, d);
    check("R7", "upper address bits ignored on read", d[7:0], 8'h22);
  endtask

  task automatic t_abort();
    logic [7:0]  s, r;
    logic [31:0] d;
    op1(8'h06); mem_wr(16'h0200, 32'h3C, 1);
    op1(8'h06);
    sel(); xfer(8'h02, r); xfer(8'h02, r); xfer(8'h00, r); bits(8'hFF, 4, r); desel();
    rd_sr(s);
    check("R10", "latch kept after partial data byte", s, 8'h02);
    mem_rd(16'h0200, 1, d);
    check("R10", "partial byte not stored", d[7:0], 8'h3C);
    sel(); xfer(8'h02, r); xfer(8'h02, r); xfer(8'h00, r); desel();
    rd_sr(s);
    check("R10", "latch kept after address-only write", s, 8'h02);
    sel(); bits(8'h04, 5, r); desel();
    rd_sr(s);
    check("R10", "partial op-code ignored", s, 8'h02);
    op1(8'h04);
  endtask

  task automatic t_unknown();
    logic [7:0] s, r0, r1, r2;
    op1(8'h06);
    sel(); xfer(8'hAB, r0); xfer(8'h04, r1); xfer(8'h05, r2); desel();
    check("R11", "miso after unknown op", r1, 8'h00);
    check("R11", "miso later slot", r2, 8'h00);
    rd_sr(s);
    check("R11", "no state change after unknown op", s, 8'h02);
    op1(8'h04);
  endtask

  task automatic t_id();
    logic [7:0] r;
    logic [7:0] exp [4] = '{8'h5A, 8'hA5, 8'h3C, 8'h5A};
    sel(); xfer(8'h9F, r);
    for (int k = 0; k < 4; k++) begin
      xfer(8'h00, r);
      check("R12", "identity byte", r, exp[k]);
    end
    desel();
  endtask

  initial begin
    t_reset();
    t_latch();
    t_sr_repeat();
    t_wrsr();
    t_mem();
    t_wrap();
    t_abort();
    t_unknown();
    t_id();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule